// File: doc/BRIEF.md
# Dual-Format Audio Serial Transmitter

This block drives the one-wire serial data output of a stereo audio link. It takes left and right signed samples from a parallel holding register and sends them MSB first. The output is timed by a bit clock and a frame clock that are produced elsewhere: they may come from a local generator or from a remote master. Both clocks arrive as ordinary inputs and are sampled by the block's own system clock. That clock must run at least four times faster than the bit clock.

One input picks the frame layout. In left-justified layout the left word goes out while the frame clock is high, and its MSB takes the first bit slot after the frame-clock transition. In I2S layout the left word goes out while the frame clock is low, and its MSB is one bit slot later. A single shift register serves both layouts. Slots after the last data bit carry zeros. A frame-clock transition that arrives early cuts the current word short and starts the next one cleanly. A power-down input forces the output low and clears all framing state.

Top module: `pcm_frame_tx`

## Requirements
- R1: After reset, and after every power-down, `sdata` stays 0 until the first left-channel frame start. A frame start is a frame-clock level, sampled at a bit-clock rising edge, that differs from the level sampled at the previous rising edge. It takes effect at the bit-clock falling edge where the new level is first seen.
- R2: While `pwr_dn` is 1, `sdata` is 0 from the next system-clock edge on, and all framing state is cleared.
- R3: `sdata` changes only in the system-clock cycle that follows a detected bit-clock falling edge (or a power-down). It holds steady through the rest of the bit period, including the rising edge.
- R4: With `fmt_i2s`=0 (left-justified), the left channel is the half-frame in which `lrck`=1. Slot 0 (the bit period that begins at the frame-start fall) carries bit WORD_W-1, and slot s carries bit WORD_W-1-s for s < WORD_W.
- R5: With `fmt_i2s`=1 (I2S), the left channel is the half-frame in which `lrck`=0. Slot s carries bit WORD_W-s for 1 ≤ s ≤ WORD_W.
- R6: Every slot after the last data bit of a half-frame carries 0. Those are slots s ≥ WORD_W in left-justified layout and slots s ≥ WORD_W+1 in I2S layout.
- R7: Both samples are captured from `left_smp` and `right_smp` at the left-channel frame start. The right half-frame sends that captured right word, even if the inputs change during the left half-frame.
- R8: A frame start that comes before the current word has been fully sent abandons the rest of that word. The new half-frame sends its own complete word from its first data slot.
- R9: In I2S layout, slot 0 of a half-frame carries the LSB of the preceding word when the preceding half-frame was exactly WORD_W slots long. Otherwise slot 0 carries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bit and frame clocks |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down: forces output low, clears framing state |
| fmt_i2s | input | 1 | Frame layout: 0 left-justified, 1 I2S |
| bclk | input | 1 | Bit clock |
| lrck | input | 1 | Frame (channel) clock |
| left_smp | input | WORD_W | Left sample, two's complement |
| right_smp | input | WORD_W | Right sample, two's complement |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with its default WORD_W of 24 and runs the bit clock at four system clocks per bit. Because of this, half-frames of 20, 24, 25, 32 and 40 slots are all reachable cheaply. That range covers the full 64-slot frame, the minimum 48-slot frame (which in I2S layout pushes the LSB into the next half-frame), a one-slot-longer frame, early frame edges that truncate words, and long zero-padded tails. Each length runs in both layouts with sign-bit, all-ones, single-bit and scrambled words. Power-down is tested mid-word as well as across each layout switch. The sample inputs are rewritten during every left half-frame to expose any late capture.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int DEF_WORD_W = 24;

    typedef enum logic {
        FMT_LEFT_JUST = 1'b0,
        FMT_I2S       = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } bclk_evt_t;

    typedef struct packed {
        logic start;
        logic is_left;
    } frame_evt_t;

    // Frame-clock level that marks the left channel for a given layout.
    function automatic logic left_level(input frame_fmt_e f);
        return (f == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/pcm_tx_edge_det.sv
module pcm_tx_edge_det
    import pcm_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_dn,
    input  logic      bclk,
    output bclk_evt_t evt
);

    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
        end
    end

    always_comb begin
        evt.rise = bclk & ~bclk_q & ~pwr_dn;
        evt.fall = ~bclk & bclk_q & ~pwr_dn;
    end

endmodule

// File: rtl/pcm_tx_frame_trk.sv
module pcm_tx_frame_trk
    import pcm_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_dn,
    input  frame_fmt_e fmt,
    input  logic       lrck,
    input  bclk_evt_t  evt,
    output frame_evt_t fev
);

    logic lr_ref;
    logic ref_ok;

    // Frame clock is captured on bit-clock rising edges.
    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            lr_ref <= 1'b0;
            ref_ok <= 1'b0;
        end else if (evt.rise) begin
            lr_ref <= lrck;
            ref_ok <= 1'b1;
        end
    end

    // A new half-frame starts at the first falling edge showing a new level.
    always_comb begin
        fev.start   = evt.fall & ref_ok & (lrck != lr_ref);
        fev.is_left = (lrck == left_level(fmt));
    end

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  frame_fmt_e        fmt,
    input  logic              bit_fall,
    input  frame_evt_t        fev,
    input  logic [WORD_W-1:0] left_smp,
    input  logic [WORD_W-1:0] right_smp,
    output logic              sdata
);

    localparam int REM_W = $clog2(WORD_W + 1);

    logic              synced;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] r_hold;
    logic [REM_W-1:0]  rem;
    logic              sdata_q;
    logic [WORD_W-1:0] next_word;
    logic              accept;

    assign next_word = fev.is_left ? left_smp : r_hold;
    assign accept    = fev.start & (fev.is_left | synced);

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            synced  <= 1'b0;
            sh      <= '0;
            r_hold  <= '0;
            rem     <= '0;
            sdata_q <= 1'b0;
        end else if (bit_fall) begin
            if (accept) begin
                synced <= 1'b1;
                if (fev.is_left) begin
                    r_hold <= right_smp;
                end
                if (fmt == FMT_I2S) begin
                    // Slot 0 carries a leftover LSB or padding.
                    sdata_q <= (rem == REM_W'(1)) ? sh[WORD_W-1] : 1'b0;
                    sh      <= next_word;
                    rem     <= REM_W'(WORD_W);
                end else begin
                    sdata_q <= next_word[WORD_W-1];
                    sh      <= {next_word[WORD_W-2:0], 1'b0};
                    rem     <= REM_W'(WORD_W - 1);
                end
            end else if (fev.start) begin
                sdata_q <= 1'b0;
                rem     <= '0;
            end else if (rem != '0) begin
                sdata_q <= sh[WORD_W-1];
                sh      <= {sh[WORD_W-2:0], 1'b0};
                rem     <= rem - REM_W'(1);
            end else begin
                sdata_q <= 1'b0;
            end
        end
    end

    assign sdata = sdata_q;

endmodule

// File: rtl/pcm_frame_tx.sv
module pcm_frame_tx
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              fmt_i2s,
    input  logic              bclk,
    input  logic              lrck,
    input  logic [WORD_W-1:0] left_smp,
    input  logic [WORD_W-1:0] right_smp,
    output logic              sdata
);

    frame_fmt_e fmt;
    bclk_evt_t  evt;
    frame_evt_t fev;

    assign fmt = frame_fmt_e'(fmt_i2s);

    pcm_tx_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .pwr_dn (pwr_dn),
        .bclk   (bclk),
        .evt    (evt)
    );

    pcm_tx_frame_trk u_trk (
        .clk    (clk),
        .rst    (rst),
        .pwr_dn (pwr_dn),
        .fmt    (fmt),
        .lrck   (lrck),
        .evt    (evt),
        .fev    (fev)
    );

    pcm_tx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .pwr_dn    (pwr_dn),
        .fmt       (fmt),
        .bit_fall  (evt.fall),
        .fev       (fev),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .sdata     (sdata)
    );

endmodule

// File: rtl/pcm_frame_tx_chk.sv
module pcm_frame_tx_chk #(
    parameter int WORD_W = 24
) (
    input logic clk,
    input logic rst,
    input logic pwr_dn,
    input logic fmt_i2s,
    input logic bclk,
    input logic lrck,
    input logic sdata
);

    localparam int CW = $clog2(WORD_W + 3);

    logic          bclk_q;
    logic          lr_fall;
    logic [CW-1:0] slot_cnt;
    logic          fall_w;

    assign fall_w = ~bclk & bclk_q;

    // Independent slot counter: lrck compared between falling edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q   <= 1'b0;
            lr_fall  <= lrck;
            slot_cnt <= '0;
        end else begin
            bclk_q <= bclk;
            if (fall_w) begin
                if (lrck != lr_fall) begin
                    lr_fall  <= lrck;
                    slot_cnt <= CW'(1);
                end else if (slot_cnt <= CW'(WORD_W + 1)) begin
                    slot_cnt <= slot_cnt + CW'(1);
                end
            end
        end
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !sdata);

    assert_pd_low_R2: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !sdata);

    assert_change_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata) |-> ($past(fall_w) || $past(pwr_dn)));

    assert_tail_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (fall_w && (lrck == lr_fall) && (slot_cnt > CW'(WORD_W))) |=> !sdata);

    assert_slot0_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (fall_w && (lrck != lr_fall) && fmt_i2s && (slot_cnt > CW'(WORD_W))) |=> !sdata);

endmodule

bind pcm_frame_tx pcm_frame_tx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pwr_dn  (pwr_dn),
    .fmt_i2s (fmt_i2s),
    .bclk    (bclk),
    .lrck    (lrck),
    .sdata   (sdata)
);

// File: tb/pcm_frame_tx_test.sv
module pcm_frame_tx_test;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst;
    logic         pwr_dn;
    logic         fmt_i2s;
    logic         bclk;
    logic         lrck;
    logic [W-1:0] left_smp;
    logic [W-1:0] right_smp;
    logic         sdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    bit           synced_m = 1'b0;
    bit           pd_m = 1'b0;
    bit           prev_live = 1'b0;
    int           prev_len = 0;
    logic [W-1:0] prev_word = '0;
    logic [W-1:0] rlat = '0;
    int           pidx = 0;

    always #2.5 clk = ~clk;

    pcm_frame_tx #(.WORD_W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .pwr_dn    (pwr_dn),
        .fmt_i2s   (fmt_i2s),
        .bclk      (bclk),
        .lrck      (lrck),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .sdata     (sdata)
    );

    function automatic logic [W-1:0] pat(input int k);
        case (k % 6)
            0: return 24'h800000;
            1: return 24'h7FFFFF;
            2: return 24'h000001;
            3: return 24'hFFFFFF;
            4: return W'(24'h1 << (k % W));
            default: return W'((k * 24'h9E3779) ^ (k << 7));
        endcase
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag, input int slot);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s slot %0d fmt %0d: sdata=%b expected %b", tag, slot, fmt_i2s, got, exp);
        end
    endtask

    // One half-frame: len slots long, stopped early after stop_at slots.
    task automatic run_half(input bit is_left, input int len, input int stop_at, input int chg_at);
        logic         lv;
        logic [W-1:0] word;
        logic         carry;
        logic         exp;
        string        tag;
        lv = is_left ? ~fmt_i2s : fmt_i2s;
        carry = (fmt_i2s && prev_live && prev_len == W) ? prev_word[0] : 1'b0;
        if (!pd_m && is_left) begin
            synced_m = 1'b1;
            word = left_smp;
            rlat = right_smp;
        end else begin
            word = rlat;
        end
        for (int s = 0; s < stop_at; s++) begin
            if (is_left && s == chg_at) begin
                pidx++;
                left_smp  = pat(2 * pidx);
                right_smp = pat(2 * pidx + 1);
            end
            if (pd_m || !synced_m) exp = 1'b0;
            else if (!fmt_i2s) exp = (s < W) ? word[W-1-s] : 1'b0;
            else if (s == 0) exp = carry;
            else exp = (s <= W) ? word[W-s] : 1'b0;
            if (pd_m) tag = "R2";
            else if (!synced_m) tag = "R1";
            else if (fmt_i2s && s == 0) tag = "R9";
            else if (s >= (fmt_i2s ? W + 1 : W)) tag = "R6";
            else if (prev_live && prev_len < W) tag = "R8";
            else if (!is_left) tag = "R7";
            else tag = fmt_i2s ? "R5" : "R4";
            bclk = 1'b0;
            lrck = lv;
            repeat (2) @(negedge clk);
            chk(sdata, exp, tag, s);
            bclk = 1'b1;
            repeat (2) @(negedge clk);
            chk(sdata, exp, "R3", s);
        end
        prev_word = word;
        prev_len  = len;
        prev_live = synced_m && !pd_m;
    endtask

    initial begin
        int lens[6] = '{32, 24, 25, 20, 40, 24};
        rst = 1'b1;
        pwr_dn = 1'b0;
        fmt_i2s = 1'b0;
        bclk = 1'b1;
        lrck = 1'b0;
        left_smp = pat(0);
        right_smp = pat(1);
        repeat (4) @(negedge clk);
        chk(sdata, 1'b0, "R1", 0);
        rst = 1'b0;
        for (int f = 0; f < 2; f++) begin
            @(negedge clk);
            pwr_dn = 1'b1;
            pd_m = 1'b1;
            fmt_i2s = f[0];
            run_half(1'b0, 8, 8, -1);
            pwr_dn = 1'b0;
            pd_m = 1'b0;
            synced_m = 1'b0;
            prev_live = 1'b0;
            run_half(1'b0, 32, 32, -1);
            foreach (lens[i]) begin
                for (int r = 0; r < 2; r++) begin
                    run_half(1'b1, lens[i], lens[i], 3);
                    run_half(1'b0, lens[i], lens[i], -1);
                end
            end
            // Power-down in the middle of an all-ones word
            left_smp = '1;
            run_half(1'b1, 32, 6, -1);
            pwr_dn = 1'b1;
            pd_m = 1'b1;
            @(negedge clk);
            chk(sdata, 1'b0, "R2", 6);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            summary();
            $finish;
        end
    end

endmodule